// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block walks the column addresses of one burst inside a DRAM row. A burst-start strobe loads a start column and a direction (read or write). On each later clock the block presents the next column of the burst. The burst length and the address ordering come from configuration inputs that are sampled at the start strobe. A valid flag marks each beat and a last flag marks the final one.

A burst ends when its final beat has been presented. It also ends early when a termination strobe arrives (a precharge) or when a new start strobe arrives (a new read or write). A full-page burst has no final beat: it keeps running until a new command ends it. An option makes every write a single beat while reads keep the programmed length.

Read beats also pass through a short delay line so that the controller gets a read-data-valid flag that is delayed by the programmed CAS latency.

Top module: `burst_col_seq`

## Requirements
- R1: When `start_i` is sampled high at a clock edge with a legal configuration, the cycle after that edge shows `col_vld_o`=1 and `col_o`=`start_col_i`. After that, one new beat appears on each clock until the burst ends.
- R2: The length code `cfg_len_i` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page. `col_last_o` is high only on the final beat, and `col_vld_o` is low in the cycle after the final beat unless a new burst starts.
- R3: When `cfg_ilv_i`=0 and the length is N, beat k uses low log2(N) bits equal to (start + k) mod N, and the upper bits stay those of the start column.
- R4: When `cfg_ilv_i`=1, beat k uses low log2(N) bits equal to the start's low bits XOR k, and the upper bits stay those of the start column.
- R5: A full-page burst (code 7, sequential) steps the whole 8-bit column by one per beat and wraps from 255 to 0. It never raises `col_last_o` and runs until `term_i` or a new start.
- R6: A start with `cfg_ilv_i`=1 and code 7, or a start with code 4, 5 or 6, is rejected. No beat is produced, any running burst ends, and `cfg_err_o` is high for exactly the cycle after that edge.
- R7: A `term_i` sampled high ends a running burst, so `col_vld_o`=0 in the next cycle. A new start during a burst replaces it from the next cycle. When `start_i` and `term_i` are high together, the start wins.
- R8: With `cfg_single_wr_i`=1, a write start (`start_wr_i`=1) gives one beat with `col_last_o`=1, while a read start uses the programmed length. `col_wr_o` shows the direction of the current burst.
- R9: `rd_vld_o` equals (`col_vld_o` AND NOT `col_wr_o`) delayed by L clocks, where L=`cfg_cl_i` for values 1 to 3 and `cfg_cl_i`=0 acts as 1.
- R10: While `rst_ni` is low, `col_vld_o`, `col_last_o`, `col_wr_o`, `rd_vld_o`, `cfg_err_o` and `col_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len_i | input | 3 | Burst length code |
| cfg_ilv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| cfg_single_wr_i | input | 1 | Writes are a single beat |
| cfg_cl_i | input | CL_W | CAS latency in clocks |
| start_i | input | 1 | Burst start strobe |
| start_wr_i | input | 1 | Direction of the starting burst, 1 = write |
| start_col_i | input | COL_W | Start column |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Current column |
| col_vld_o | output | 1 | Current column is a burst beat |
| col_last_o | output | 1 | Final beat of the burst |
| col_wr_o | output | 1 | Current burst is a write |
| rd_vld_o | output | 1 | Read data valid, delayed by the latency |
| cfg_err_o | output | 1 | A start was rejected |

## Verification
The assertions check the rules that hold from one beat to the next on every cycle. These are: the last flag only appears on a valid beat, the upper bits stay fixed and sequential steps advance by one, full-page bursts step by one, single-beat writes end on their first beat, a rejected start produces no beat, and the read-valid delay line matches the programmed latency. Which column comes at which beat index depends on the start column, the length code and the ordering. So do the exact point where an interrupted burst stops, the XOR pattern of interleaving, and a full-page run passing the 255-to-0 wrap. These can only be shown by the bench's reference model across its chosen scenarios.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LEN_W = 3;
  localparam logic [LEN_W-1:0] LEN_FULL = 3'd7;
  localparam int LEN_MAX_POW = 3; // codes 0..3 give 1..8 beats

  typedef struct packed {
    logic       legal;
    logic       full;
  } len_dec_t;
endpackage

// File: rtl/bcs_cfg_check.sv
module bcs_cfg_check
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             ilv_i,
  input  logic             single_wr_i,
  input  logic             wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             legal_o
);
  len_dec_t dec;
  logic     one_beat;

  always_comb begin
    dec.full  = (len_i == LEN_FULL);
    dec.legal = (int'(len_i) <= LEN_MAX_POW) || (dec.full && !ilv_i);
  end

  assign one_beat = single_wr_i && wr_i;
  assign legal_o  = dec.legal;
  assign full_o   = dec.full && !one_beat;

  always_comb begin
    mask_o = '0;
    if (!one_beat) begin
      if (dec.full) mask_o = '1;
      else if (int'(len_i) <= LEN_MAX_POW)
        mask_o = COL_W'((1 << int'(len_i)) - 1);
    end
  end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_wr_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             term_i,
  input  logic             legal_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic             act_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             full_o,
  output logic             wr_o,
  output logic             last_o,
  output logic             err_o
);
  logic             act_q, ilv_q, full_q, wr_q, err_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             at_end;

  assign at_end = !full_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else begin
      err_q <= 1'b0;
      if (start_i) begin
        if (legal_i) begin
          act_q  <= 1'b1;
          base_q <= start_col_i;
          beat_q <= '0;
          mask_q <= mask_i;
          full_q <= full_i;
          ilv_q  <= ilv_i;
          wr_q   <= start_wr_i;
        end else begin
          act_q <= 1'b0;
          wr_q  <= 1'b0;
          err_q <= 1'b1;
        end
      end else if (term_i || (act_q && at_end)) begin
        act_q <= 1'b0;
        wr_q  <= 1'b0;
      end else if (act_q) begin
        beat_q <= beat_q + COL_W'(1);
      end
    end
  end

  assign act_o  = act_q;
  assign base_o = base_q;
  assign beat_o = beat_q;
  assign mask_o = mask_q;
  assign ilv_o  = ilv_q;
  assign full_o = full_q;
  assign wr_o   = wr_q;
  assign last_o = act_q && at_end;
  assign err_o  = err_q;

  AST_ERR_NO_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !act_q); // R6
  AST_BEAT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !full_q) |-> ((beat_q & ~mask_q) == '0)); // R2
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_off, ilv_off;

  assign seq_off = base_i + beat_i;
  assign ilv_off = base_i ^ beat_i;

  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_bit
      assign col_o[b] = mask_i[b] ? (ilv_i ? ilv_off[b] : seq_off[b]) : base_i[b];
    end
  endgenerate
endmodule

// File: rtl/bcs_lat_pipe.sv
module bcs_lat_pipe #(
  parameter int CL_MAX = 3,
  parameter int CL_W   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CL_W-1:0] cl_i,
  input  logic            in_i,
  output logic            out_o
);
  logic stg_q [CL_MAX];
  int   sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= 1'b0;
    else         stg_q[0] <= in_i;
  end

  genvar i;
  generate
    for (i = 1; i < CL_MAX; i++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 1'b0;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  endgenerate

  always_comb begin
    sel = (cl_i == '0) ? 0 : int'(cl_i) - 1;
    if (sel > CL_MAX - 1) sel = CL_MAX - 1;
  end
  assign out_o = stg_q[sel];

  AST_CL1_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_i <= CL_W'(1)) |-> (out_o == $past(in_i))); // R9
  AST_CL2_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_i == CL_W'(2) && $past(cl_i) == CL_W'(2)) |-> (out_o == $past(in_i, 2))); // R9
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int CL_MAX = 3,
  parameter int CL_W   = $clog2(CL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cfg_len_i,
  input  logic             cfg_ilv_i,
  input  logic             cfg_single_wr_i,
  input  logic [CL_W-1:0]  cfg_cl_i,
  input  logic             start_i,
  input  logic             start_wr_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             col_last_o,
  output logic             col_wr_o,
  output logic             rd_vld_o,
  output logic             cfg_err_o
);
  logic [COL_W-1:0] dec_mask, base, beat, mask;
  logic             dec_full, dec_legal, act, ilv, full, wr, last, err;
  logic [COL_W-1:0] col_raw;

  bcs_cfg_check #(.COL_W(COL_W)) u_cfg (
    .len_i       (cfg_len_i),
    .ilv_i       (cfg_ilv_i),
    .single_wr_i (cfg_single_wr_i),
    .wr_i        (start_wr_i),
    .mask_o      (dec_mask),
    .full_o      (dec_full),
    .legal_o     (dec_legal)
  );

  bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_wr_i  (start_wr_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .legal_i     (dec_legal),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .ilv_i       (cfg_ilv_i),
    .act_o       (act),
    .base_o      (base),
    .beat_o      (beat),
    .mask_o      (mask),
    .ilv_o       (ilv),
    .full_o      (full),
    .wr_o        (wr),
    .last_o      (last),
    .err_o       (err)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (ilv),
    .col_o  (col_raw)
  );

  bcs_lat_pipe #(.CL_MAX(CL_MAX), .CL_W(CL_W)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cl_i   (cfg_cl_i),
    .in_i   (act && !wr),
    .out_o  (rd_vld_o)
  );

  assign col_o      = act ? col_raw : '0;
  assign col_vld_o  = act;
  assign col_last_o = last;
  assign col_wr_o   = wr;
  assign cfg_err_o  = err;

  AST_LAST_NEEDS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_last_o |-> col_vld_o); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_vld_o && $past(col_vld_o) && !$past(start_i) && !full)
      |-> ((col_o & ~mask) == ($past(col_o) & ~mask))); // R3
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_vld_o && $past(col_vld_o) && !$past(start_i) && !ilv)
      |-> (((col_o - $past(col_o)) & mask) == (COL_W'(1) & mask))); // R5
  AST_SINGLE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && start_wr_i && cfg_single_wr_i && !(cfg_ilv_i && cfg_len_i == LEN_FULL)
      && (int'(cfg_len_i) <= LEN_MAX_POW || cfg_len_i == LEN_FULL))
      |=> (col_last_o && col_wr_o)); // R8
  AST_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cfg_ilv_i && cfg_len_i == LEN_FULL) |=> (!col_vld_o && cfg_err_o)); // R6
  AST_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !start_i) |=> !col_vld_o); // R7
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_len = '0;
  logic       cfg_ilv = 1'b0, cfg_sw = 1'b0;
  logic [1:0] cfg_cl = 2'd1;
  logic       start = 1'b0, start_wr = 1'b0, term = 1'b0;
  logic [7:0] start_col = '0;
  logic [7:0] col;
  logic       col_vld, col_last, col_wr, rd_vld, cfg_err;

  int n_chk = 0, n_fail = 0;
  bit chk_en = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  burst_col_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_len_i(cfg_len), .cfg_ilv_i(cfg_ilv),
    .cfg_single_wr_i(cfg_sw), .cfg_cl_i(cfg_cl), .start_i(start),
    .start_wr_i(start_wr), .start_col_i(start_col), .term_i(term),
    .col_o(col), .col_vld_o(col_vld), .col_last_o(col_last), .col_wr_o(col_wr),
    .rd_vld_o(rd_vld), .cfg_err_o(cfg_err)
  );

  // reference model
  int m_act, m_base, m_k, m_n, m_ilv, m_wr, m_err;
  int hist[4];

  function automatic int exp_col();
    int lo, blk;
    if (m_n == 0) return (m_base + m_k) % 256;
    lo  = m_base % m_n;
    blk = m_base - lo;
    if (m_ilv != 0) return blk + (lo ^ m_k);
    return blk + ((lo + m_k) % m_n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_base = 0; m_k = 0; m_n = 1; m_ilv = 0; m_wr = 0; m_err = 0;
      foreach (hist[i]) hist[i] = 0;
    end else begin
      hist[3] = hist[2]; hist[2] = hist[1];
      hist[1] = (m_act != 0 && m_wr == 0) ? 1 : 0;
      m_err = 0;
      if (start) begin
        if ((cfg_len <= 3 || cfg_len == 7) && !(cfg_ilv && cfg_len == 7)) begin
          m_act = 1; m_base = start_col; m_k = 0; m_ilv = cfg_ilv; m_wr = start_wr;
          if (start_wr && cfg_sw) m_n = 1;
          else if (cfg_len == 7) m_n = 0;
          else m_n = 1 << cfg_len;
        end else begin
          m_act = 0; m_wr = 0; m_err = 1;
        end
      end else if (term) begin
        m_act = 0; m_wr = 0;
      end else if (m_act != 0) begin
        if (m_n != 0 && m_k == m_n - 1) begin m_act = 0; m_wr = 0; end
        else m_k = (m_k + 1) % 256;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      int e_last, cl_eff;
      e_last = (m_act != 0 && m_n != 0 && m_k == m_n - 1) ? 1 : 0;
      cl_eff = (cfg_cl == 0) ? 1 : cfg_cl;
      check(col_vld == m_act[0], tag, "col_vld", col_vld, m_act);
      check(col_last == e_last[0], tag, "col_last", col_last, e_last);
      if (m_act != 0) check(col == exp_col(), tag, "col", col, exp_col());
      check(col_wr == m_wr[0], "R8", "col_wr", col_wr, m_wr);
      check(rd_vld == hist[cl_eff][0], "R9", "rd_vld", rd_vld, hist[cl_eff]);
      check(cfg_err == m_err[0], "R6", "cfg_err", cfg_err, m_err);
    end
  end

  task automatic go(input logic [2:0] len, input logic ilv, input logic wr, input logic [7:0] c);
    @(posedge clk); #2;
    cfg_len = len; cfg_ilv = ilv; start_wr = wr; start_col = c; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R10 reset state
    check({col_vld, col_last, col_wr, rd_vld, cfg_err} == 5'b0 && col == 8'h0,
          "R10", "outputs in reset", {col_vld, col_last, col_wr, rd_vld, cfg_err}, 0);
    #3 rst_n = 1'b1;
    chk_en = 1;
    cfg_cl = 2'd2;
    tag = "R3"; go(3'd2, 0, 0, 8'h0E); idle(6);   // 14,15,12,13
    tag = "R3"; go(3'd3, 0, 0, 8'hA3); idle(10);
    tag = "R4"; go(3'd3, 1, 0, 8'h35); idle(10);  // 53,52,55,54,49,48,51,50
    tag = "R4"; go(3'd1, 1, 0, 8'h11); idle(4);
    tag = "R2"; go(3'd0, 0, 0, 8'h7F); idle(4);
    tag = "R1"; cfg_cl = 2'd1; go(3'd2, 1, 0, 8'hFE); idle(6);
    tag = "R9"; cfg_cl = 2'd3; go(3'd2, 0, 0, 8'h40); idle(8);
    cfg_cl = 2'd0; go(3'd1, 0, 0, 8'h41); idle(6);
    cfg_cl = 2'd2;
    tag = "R5"; go(3'd7, 0, 0, 8'hFD); idle(300);
    @(posedge clk); #2 term = 1'b1; @(posedge clk); #2 term = 1'b0; idle(4);
    tag = "R6"; go(3'd3, 0, 0, 8'h20); idle(2);
    go(3'd7, 1, 0, 8'h20); idle(4);
    go(3'd5, 0, 1, 8'h30); idle(3);
    tag = "R7"; go(3'd3, 0, 0, 8'h50); idle(2);
    go(3'd2, 1, 1, 8'h66); idle(1);
    @(posedge clk); #2 term = 1'b1; @(posedge clk); #2 term = 1'b0; idle(3);
    go(3'd3, 0, 0, 8'h08); idle(1);
    @(posedge clk); #2 term = 1'b1; start = 1'b1; start_col = 8'h90; cfg_len = 3'd1;
    @(posedge clk); #2 term = 1'b0; start = 1'b0; idle(4);
    tag = "R8"; cfg_sw = 1'b1; go(3'd3, 0, 1, 8'h12); idle(3);
    go(3'd3, 0, 0, 8'h12); idle(10);
    go(3'd7, 0, 1, 8'h12); idle(3);
    cfg_sw = 1'b0; go(3'd2, 0, 1, 8'h2D); idle(6);
    chk_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule